// File: doc/BRIEF.md
# Peripheral Security Access Filter

This block stands between an APB-style master and a set of peripheral ports. Address decode upstream raises one bit of a one-hot select vector to pick the target port. For each transfer the filter compares the transfer's protection attributes with two configuration bits for the selected port. One bit allows non-secure access and the other allows unprivileged access. A transfer that passes both checks goes through to its port unchanged. A transfer that fails a check never reaches any port, and the filter completes it locally.

A global input sets how a blocked transfer ends. In one mode it ends with an error response. In the other it ends without error, reads return zero and writes are dropped. A sticky interrupt flag records blocked accesses while the interrupt is enabled, and an input pulse clears it. A build-time mask removes the security check from chosen ports, but the privilege check still applies to them. All configuration arrives on input wires, and the block has no register interface.

Top module: `periph_sec_filter`

## Requirements
- R1: When exactly one select bit is set and the transfer passes both checks for that port, `dn_sel` equals `up_sel`, `dn_enable` follows `up_enable`, and `up_rdata`, `up_ready` and `up_slverr` are taken from that port's response inputs.
- R2: `up_prot[1]`=1 marks a transfer as non-secure. A non-secure transfer to port i is blocked when `allow_nonsec[i]`=0, unless the port is exempt under R4. Secure transfers always pass this check.
- R3: `up_prot[0]`=1 marks a transfer as privileged. An unprivileged transfer to port i is blocked when `allow_user[i]`=0, and this check applies to exempt ports as well.
- R4: A port whose bit is set in the parameter `SEC_EXEMPT` accepts non-secure transfers whatever `allow_nonsec` says.
- R5: A blocked transfer is never forwarded: `dn_sel` is all zeros and `dn_enable` is 0.
- R6: With `deny_is_error`=1, a blocked access cycle (`up_enable`=1) returns `up_ready`=1, `up_slverr`=1 and `up_rdata`=0.
- R7: With `deny_is_error`=0, a blocked access cycle returns `up_ready`=1, `up_slverr`=0 and `up_rdata`=0, and the write reaches no port.
- R8: An access cycle whose `up_sel` has no bit set, or more than one bit set, is blocked.
- R9: A blocked access cycle while `irq_en`=1 sets `irq` from the next clock edge. `irq` then stays high until it is cleared.
- R10: While `irq_en`=0, blocked accesses do not set `irq`.
- R11: `irq_clr`=1 clears `irq` at the next edge. If a blocked access that sets `irq` under R9 happens in the same cycle, `irq` stays set.
- R12: While `rst` is high, `irq` is cleared at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_sel | input | NPORTS | One-hot port select from upstream decode |
| up_enable | input | 1 | Access phase strobe |
| up_write | input | 1 | Write when 1 |
| up_addr | input | ADDR_W | Transfer address |
| up_wdata | input | DATA_W | Write data |
| up_prot | input | 3 | Protection: bit 1 non-secure, bit 0 privileged |
| up_rdata | output | DATA_W | Read data returned upstream |
| up_ready | output | 1 | Transfer completion |
| up_slverr | output | 1 | Error response |
| dn_sel | output | NPORTS | Per-port select driven downstream |
| dn_enable | output | 1 | Access strobe driven downstream |
| dn_write | output | 1 | Write flag driven downstream |
| dn_addr | output | ADDR_W | Address driven downstream |
| dn_wdata | output | DATA_W | Write data driven downstream |
| dn_prot | output | 3 | Protection attributes driven downstream |
| dn_rdata | input | NPORTS*DATA_W | Read data of all ports, port i at slice i |
| dn_ready | input | NPORTS | Ready of each port |
| dn_slverr | input | NPORTS | Error response of each port |
| allow_nonsec | input | NPORTS | Per-port permission for non-secure transfers |
| allow_user | input | NPORTS | Per-port permission for unprivileged transfers |
| deny_is_error | input | 1 | Blocked transfers: 1 error, 0 read-zero/write-drop |
| irq_en | input | 1 | Enables recording of blocked accesses |
| irq_clr | input | 1 | Clears the recorded status |
| irq | output | 1 | Sticky blocked-access interrupt |

## Verification
The checks run every combination of secure and non-secure with privileged and unprivileged attributes against ports that allow or refuse each attribute. This shows which of the two checks caused a block. An exempt port is then given a non-secure and an unprivileged transfer, which shows that the mask removes only the security check. Empty and double selects are also tried, and both response modes are applied to reads and writes. Together these separate error completion from zero-data completion and show that no write reaches a port. Downstream error and wait responses are driven on permitted ports to confirm they pass through unchanged. The interrupt is then set, held, cleared, left untouched while disabled, and given a clear and a fresh block in the same cycle.

// File: rtl/psf_pkg.sv
package psf_pkg;

    localparam int PROT_W        = 3;
    localparam int PROT_NS_BIT   = 1;
    localparam int PROT_PRIV_BIT = 0;
    localparam int SEL_MAX       = 32;

    typedef struct packed {
        logic nonsec;
        logic priv;
    } xfer_attr_t;

    typedef enum logic [1:0] {
        VERD_IDLE     = 2'd0,
        VERD_PASS     = 2'd1,
        VERD_DENY_ERR = 2'd2,
        VERD_DENY_RAZ = 2'd3
    } verdict_e;

    function automatic xfer_attr_t decode_prot(input logic [PROT_W-1:0] p);
        xfer_attr_t a;
        a.nonsec = p[PROT_NS_BIT];
        a.priv   = p[PROT_PRIV_BIT];
        return a;
    endfunction

    function automatic logic exactly_one(input logic [SEL_MAX-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic is_denied(input verdict_e v);
        return (v == VERD_DENY_ERR) || (v == VERD_DENY_RAZ);
    endfunction

endpackage

// File: rtl/psf_port_gate.sv
module psf_port_gate
    import psf_pkg::*;
#(
    parameter int                NPORTS     = 16,
    parameter logic [NPORTS-1:0] SEC_EXEMPT = '0
) (
    input  xfer_attr_t        attr,
    input  logic [NPORTS-1:0] allow_nonsec,
    input  logic [NPORTS-1:0] allow_user,
    output logic [NPORTS-1:0] port_ok
);

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        logic sec_ok;
        logic priv_ok;
        if (SEC_EXEMPT[i]) begin : g_exempt
            assign sec_ok = 1'b1;
        end else begin : g_checked
            assign sec_ok = allow_nonsec[i] | ~attr.nonsec;
        end
        assign priv_ok    = allow_user[i] | attr.priv;
        assign port_ok[i] = sec_ok & priv_ok;
    end

endmodule

// File: rtl/psf_resp_mux.sv
module psf_resp_mux #(
    parameter int NPORTS = 16,
    parameter int DATA_W = 32
) (
    input  logic [NPORTS-1:0]        sel,
    input  logic [NPORTS*DATA_W-1:0] port_rdata,
    input  logic [NPORTS-1:0]        port_ready,
    input  logic [NPORTS-1:0]        port_slverr,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ready,
    output logic                     slverr
);

    logic [DATA_W-1:0] masked [NPORTS];

    for (genvar i = 0; i < NPORTS; i++) begin : g_mask
        assign masked[i] = port_rdata[i*DATA_W +: DATA_W] & {DATA_W{sel[i]}};
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPORTS; i++) begin
            rdata = rdata | masked[i];
        end
        ready  = |(sel & port_ready);
        slverr = |(sel & port_slverr);
    end

endmodule

// File: rtl/psf_irq_flag.sv
module psf_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic deny_hit,
    input  logic enable,
    input  logic clear,
    output logic flag
);

    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clear) begin
            flag_d = 1'b0;
        end
        if (deny_hit && enable) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/periph_sec_filter.sv
module periph_sec_filter
    import psf_pkg::*;
#(
    parameter int                NPORTS     = 16,
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter logic [NPORTS-1:0] SEC_EXEMPT = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        up_sel,
    input  logic                     up_enable,
    input  logic                     up_write,
    input  logic [ADDR_W-1:0]        up_addr,
    input  logic [DATA_W-1:0]        up_wdata,
    input  logic [2:0]               up_prot,
    output logic [DATA_W-1:0]        up_rdata,
    output logic                     up_ready,
    output logic                     up_slverr,
    output logic [NPORTS-1:0]        dn_sel,
    output logic                     dn_enable,
    output logic                     dn_write,
    output logic [ADDR_W-1:0]        dn_addr,
    output logic [DATA_W-1:0]        dn_wdata,
    output logic [2:0]               dn_prot,
    input  logic [NPORTS*DATA_W-1:0] dn_rdata,
    input  logic [NPORTS-1:0]        dn_ready,
    input  logic [NPORTS-1:0]        dn_slverr,
    input  logic [NPORTS-1:0]        allow_nonsec,
    input  logic [NPORTS-1:0]        allow_user,
    input  logic                     deny_is_error,
    input  logic                     irq_en,
    input  logic                     irq_clr,
    output logic                     irq
);

    xfer_attr_t         attr;
    logic [NPORTS-1:0]  port_ok;
    logic [SEL_MAX-1:0] sel_wide;
    logic               sel_valid;
    logic               permit;
    verdict_e           verdict;
    logic [DATA_W-1:0]  mux_rdata;
    logic               mux_ready;
    logic               mux_slverr;
    logic               deny_hit;

    assign attr = decode_prot(up_prot);

    psf_port_gate #(
        .NPORTS     (NPORTS),
        .SEC_EXEMPT (SEC_EXEMPT)
    ) u_gate (
        .attr         (attr),
        .allow_nonsec (allow_nonsec),
        .allow_user   (allow_user),
        .port_ok      (port_ok)
    );

    always_comb begin
        sel_wide             = '0;
        sel_wide[NPORTS-1:0] = up_sel;
    end

    assign sel_valid = exactly_one(sel_wide);
    assign permit    = sel_valid && ((up_sel & port_ok) != '0);

    always_comb begin
        if (permit) begin
            verdict = VERD_PASS;
        end else if (up_enable || (up_sel != '0)) begin
            verdict = deny_is_error ? VERD_DENY_ERR : VERD_DENY_RAZ;
        end else begin
            verdict = VERD_IDLE;
        end
    end

    psf_resp_mux #(
        .NPORTS (NPORTS),
        .DATA_W (DATA_W)
    ) u_mux (
        .sel         (up_sel),
        .port_rdata  (dn_rdata),
        .port_ready  (dn_ready),
        .port_slverr (dn_slverr),
        .rdata       (mux_rdata),
        .ready       (mux_ready),
        .slverr      (mux_slverr)
    );

    always_comb begin
        unique case (verdict)
            VERD_PASS: begin
                up_rdata  = mux_rdata;
                up_ready  = mux_ready;
                up_slverr = mux_slverr;
            end
            VERD_DENY_ERR: begin
                up_rdata  = '0;
                up_ready  = 1'b1;
                up_slverr = up_enable;
            end
            VERD_DENY_RAZ: begin
                up_rdata  = '0;
                up_ready  = 1'b1;
                up_slverr = 1'b0;
            end
            default: begin
                up_rdata  = '0;
                up_ready  = 1'b1;
                up_slverr = 1'b0;
            end
        endcase
    end

    assign dn_sel    = permit ? up_sel : '0;
    assign dn_enable = permit & up_enable;
    assign dn_write  = up_write;
    assign dn_addr   = up_addr;
    assign dn_wdata  = up_wdata;
    assign dn_prot   = up_prot;

    assign deny_hit = up_enable && is_denied(verdict);

    psf_irq_flag u_irq (
        .clk      (clk),
        .rst      (rst),
        .deny_hit (deny_hit),
        .enable   (irq_en),
        .clear    (irq_clr),
        .flag     (irq)
    );

endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
    parameter int                NPORTS     = 16,
    parameter int                DATA_W     = 32,
    parameter logic [NPORTS-1:0] SEC_EXEMPT = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [NPORTS-1:0] up_sel,
    input logic              up_enable,
    input logic [2:0]        up_prot,
    input logic [DATA_W-1:0] up_rdata,
    input logic              up_ready,
    input logic              up_slverr,
    input logic [NPORTS-1:0] dn_sel,
    input logic              dn_enable,
    input logic [NPORTS-1:0] allow_nonsec,
    input logic [NPORTS-1:0] allow_user,
    input logic              deny_is_error,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              irq
);

    logic blocked_access;
    assign blocked_access = up_enable && (dn_sel == '0);

    assert_fwd_matches_R1: assert property (@(posedge clk) disable iff (rst)
        (dn_sel != '0) |-> (($onehot(up_sel)) && (dn_sel == up_sel)));

    assert_ns_refused_R2: assert property (@(posedge clk) disable iff (rst)
        (up_prot[1] && ((up_sel & ~allow_nonsec & ~SEC_EXEMPT) != '0)) |-> (dn_sel == '0));

    assert_user_refused_R3: assert property (@(posedge clk) disable iff (rst)
        (!up_prot[0] && ((up_sel & ~allow_user) != '0)) |-> (dn_sel == '0));

    assert_no_enable_when_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (dn_sel == '0) |-> !dn_enable);

    assert_err_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (blocked_access && deny_is_error) |-> (up_ready && up_slverr && (up_rdata == '0)));

    assert_raz_mode_R7: assert property (@(posedge clk) disable iff (rst)
        (blocked_access && !deny_is_error) |-> (up_ready && !up_slverr && (up_rdata == '0)));

    assert_bad_sel_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (up_enable && ($countones(up_sel) != 1)) |-> (dn_sel == '0));

    assert_irq_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (blocked_access && irq_en) |=> irq);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!irq && !irq_en) |=> !irq);

    assert_irq_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !(blocked_access && irq_en)) |=> !irq);

    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> !irq);

endmodule

bind periph_sec_filter psf_checker #(
    .NPORTS     (NPORTS),
    .DATA_W     (DATA_W),
    .SEC_EXEMPT (SEC_EXEMPT)
) u_psf_checker (
    .clk           (clk),
    .rst           (rst),
    .up_sel        (up_sel),
    .up_enable     (up_enable),
    .up_prot       (up_prot),
    .up_rdata      (up_rdata),
    .up_ready      (up_ready),
    .up_slverr     (up_slverr),
    .dn_sel        (dn_sel),
    .dn_enable     (dn_enable),
    .allow_nonsec  (allow_nonsec),
    .allow_user    (allow_user),
    .deny_is_error (deny_is_error),
    .irq_en        (irq_en),
    .irq_clr       (irq_clr),
    .irq           (irq)
);

// File: tb/periph_sec_filter_bench.sv
module periph_sec_filter_bench;

    localparam int                NP  = 16;
    localparam int                AW  = 12;
    localparam int                DW  = 32;
    localparam logic [NP-1:0]     EXM = 16'h0081;

    logic            clk = 1'b0;
    logic            rst;
    logic [NP-1:0]   up_sel;
    logic            up_enable;
    logic            up_write;
    logic [AW-1:0]   up_addr;
    logic [DW-1:0]   up_wdata;
    logic [2:0]      up_prot;
    logic [DW-1:0]   up_rdata;
    logic            up_ready;
    logic            up_slverr;
    logic [NP-1:0]   dn_sel;
    logic            dn_enable;
    logic            dn_write;
    logic [AW-1:0]   dn_addr;
    logic [DW-1:0]   dn_wdata;
    logic [2:0]      dn_prot;
    logic [NP*DW-1:0] dn_rdata;
    logic [NP-1:0]   dn_ready;
    logic [NP-1:0]   dn_slverr;
    logic [NP-1:0]   allow_nonsec;
    logic [NP-1:0]   allow_user;
    logic            deny_is_error;
    logic            irq_en;
    logic            irq_clr;
    logic            irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    periph_sec_filter #(
        .NPORTS     (NP),
        .ADDR_W     (AW),
        .DATA_W     (DW),
        .SEC_EXEMPT (EXM)
    ) u_periph_sec_filter (
        .clk (clk), .rst (rst),
        .up_sel (up_sel), .up_enable (up_enable), .up_write (up_write),
        .up_addr (up_addr), .up_wdata (up_wdata), .up_prot (up_prot),
        .up_rdata (up_rdata), .up_ready (up_ready), .up_slverr (up_slverr),
        .dn_sel (dn_sel), .dn_enable (dn_enable), .dn_write (dn_write),
        .dn_addr (dn_addr), .dn_wdata (dn_wdata), .dn_prot (dn_prot),
        .dn_rdata (dn_rdata), .dn_ready (dn_ready), .dn_slverr (dn_slverr),
        .allow_nonsec (allow_nonsec), .allow_user (allow_user),
        .deny_is_error (deny_is_error), .irq_en (irq_en), .irq_clr (irq_clr),
        .irq (irq)
    );

    function automatic logic [DW-1:0] port_word(input int i);
        return 32'hC0DE_0000 + 32'(i * 17 + 1);
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Setup phase then access phase; checks are made 1 ns into the access cycle.
    task automatic access(input logic [NP-1:0] sel, input logic wr, input logic [2:0] prot);
        @(negedge clk);
        up_sel = sel; up_write = wr; up_prot = prot; up_enable = 1'b0;
        up_addr = 12'h3A4; up_wdata = 32'h5555_AAAA;
        @(negedge clk);
        up_enable = 1'b1;
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        up_sel = '0; up_enable = 1'b0; irq_clr = 1'b0;
        #1;
    endtask

    task automatic expect_pass(input string req, input int port);
        check({req, " dn_sel"}, 32'(dn_sel), 32'(1 << port));
        check({req, " dn_enable"}, 32'(dn_enable), 32'd1);
        check({req, " rdata"}, up_rdata, port_word(port));
    endtask

    task automatic expect_block(input string req, input logic err);
        check({req, " dn_sel"}, 32'(dn_sel), 32'd0);
        check({req, " dn_enable"}, 32'(dn_enable), 32'd0);
        check({req, " ready"}, 32'(up_ready), 32'd1);
        check({req, " slverr"}, 32'(up_slverr), 32'(err));
        check({req, " rdata"}, up_rdata, 32'd0);
    endtask

    task automatic t_reset();
        check("R12 irq after reset", 32'(irq), 32'd0);
        check("R5 idle dn_sel", 32'(dn_sel), 32'd0);
    endtask

    task automatic t_security();
        allow_nonsec = '0; allow_user = '1; deny_is_error = 1'b1;
        access(16'h0008, 1'b0, 3'b001);  expect_pass("R1 secure priv port3", 3);
        access(16'h0008, 1'b0, 3'b000);  expect_pass("R1 secure user port3", 3);
        access(16'h0008, 1'b0, 3'b011);  expect_block("R2 nonsec port3 refused", 1'b1);
        allow_nonsec = 16'h0008;
        access(16'h0008, 1'b0, 3'b011);  expect_pass("R2 nonsec port3 allowed", 3);
        go_idle();
    endtask

    task automatic t_privilege();
        allow_nonsec = '1; allow_user = 16'hFFFB; deny_is_error = 1'b1;
        access(16'h0004, 1'b0, 3'b010);  expect_block("R3 user port2 refused", 1'b1);
        access(16'h0004, 1'b0, 3'b011);  expect_pass("R3 priv port2 allowed", 2);
        allow_user = '1;
        access(16'h0004, 1'b0, 3'b010);  expect_pass("R3 user port2 allowed", 2);
        go_idle();
    endtask

    task automatic t_exempt();
        allow_nonsec = '0; allow_user = 16'hFF7F; deny_is_error = 1'b1;
        access(16'h0080, 1'b0, 3'b011);  expect_pass("R4 exempt port7 nonsec", 7);
        access(16'h0001, 1'b0, 3'b011);  check("R4 exempt port0 nonsec", 32'(dn_sel), 32'h1);
        access(16'h0080, 1'b0, 3'b010);  expect_block("R3 exempt port7 user refused", 1'b1);
        access(16'h0002, 1'b0, 3'b011);  expect_block("R4 port1 not exempt", 1'b1);
        go_idle();
    endtask

    task automatic t_raz();
        allow_nonsec = '0; allow_user = '1; deny_is_error = 1'b0;
        access(16'h0010, 1'b1, 3'b011);  expect_block("R7 raz write port4", 1'b0);
        check("R5 write dn_enable", 32'(dn_enable), 32'd0);
        access(16'h0010, 1'b0, 3'b011);  expect_block("R7 raz read port4", 1'b0);
        deny_is_error = 1'b1;
        access(16'h0010, 1'b1, 3'b011);  expect_block("R6 err write port4", 1'b1);
        go_idle();
    endtask

    task automatic t_passthrough();
        allow_nonsec = '1; allow_user = '1; deny_is_error = 1'b1;
        dn_slverr[5] = 1'b1;
        access(16'h0020, 1'b0, 3'b001);
        check("R1 port5 slverr passes", 32'(up_slverr), 32'd1);
        dn_slverr[5] = 1'b0;
        dn_ready[6] = 1'b0;
        access(16'h0040, 1'b0, 3'b001);
        check("R1 port6 wait passes", 32'(up_ready), 32'd0);
        check("R1 port6 dn_sel", 32'(dn_sel), 32'h40);
        dn_ready[6] = 1'b1;
        #1;
        check("R1 port6 ready passes", 32'(up_ready), 32'd1);
        go_idle();
    endtask

    task automatic t_bad_sel();
        allow_nonsec = '1; allow_user = '1; deny_is_error = 1'b1;
        access(16'h0000, 1'b0, 3'b001);  expect_block("R8 empty select err", 1'b1);
        access(16'h0011, 1'b0, 3'b001);  expect_block("R8 double select err", 1'b1);
        deny_is_error = 1'b0;
        access(16'h8001, 1'b1, 3'b001);  expect_block("R8 double select raz", 1'b0);
        go_idle();
    endtask

    task automatic t_irq();
        allow_nonsec = '0; allow_user = '1; deny_is_error = 1'b1;
        irq_en = 1'b0;
        access(16'h0004, 1'b0, 3'b011);
        go_idle();
        check("R10 disabled no irq", 32'(irq), 32'd0);
        irq_en = 1'b1;
        access(16'h0004, 1'b0, 3'b011);
        go_idle();
        check("R9 irq set", 32'(irq), 32'd1);
        access(16'h0004, 1'b0, 3'b001);
        go_idle();
        check("R9 irq sticky", 32'(irq), 32'd1);
        irq_en = 1'b0;
        access(16'h0004, 1'b0, 3'b011);
        go_idle();
        check("R10 disabled keeps irq", 32'(irq), 32'd1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0; #1;
        check("R11 irq cleared", 32'(irq), 32'd0);
        irq_en = 1'b1;
        access(16'h0004, 1'b0, 3'b011);
        irq_clr = 1'b1;
        go_idle();
        check("R11 new block beats clear", 32'(irq), 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R12 reset clears irq", 32'(irq), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) dn_rdata[i*DW +: DW] = port_word(i);
        dn_ready = '1; dn_slverr = '0;
        up_sel = '0; up_enable = 1'b0; up_write = 1'b0; up_addr = '0;
        up_wdata = '0; up_prot = 3'b001;
        allow_nonsec = '0; allow_user = '0; deny_is_error = 1'b0;
        irq_en = 1'b0; irq_clr = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_security();
        t_privilege();
        t_exempt();
        t_raz();
        t_passthrough();
        t_bad_sel();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule